// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into physical register numbers for one rename slot of an out-of-order core. One architectural index space is split into three ranges: integer, floating point and miscellaneous. The integer and floating-point ranges each have their own mapping table and their own pool of free physical registers. The miscellaneous range is never renamed. Each miscellaneous index maps to a fixed physical index above all renameable physical registers.

A combinational lookup port reads the current mapping. The rename port pulls a fresh physical register from the matching pool. In the same cycle it reports both the new register and the mapping it replaces, so retire logic can later free the old one. A set-entry port overwrites a mapping during recovery. A release port gives freed physical registers back to their pool. The `free_slots` output reports how many renames are certain to succeed: the smaller of the two pool occupancies.

Both data ports use valid/ready. A rename transfers on a cycle where `ren_valid` and `ren_ready` are both high. `ren_ready` drops only when the pool the request needs is empty. The requester must then hold or retry, and nothing in the block changes. A release transfers when `rel_valid` and `rel_ready` are both high. `rel_ready` drops only when the target pool is full. Lookup, set-entry and `free_slots` are plain control and status pins.

Top module: `rename_map`

## Requirements
- R1: After reset, integer architectural register i maps to physical i. Floating-point architectural register NLI+j maps to physical NPI+j. The integer pool holds NLI..NPI-1 in ascending pop order. The float pool holds NPI+NLF..NPI+NPF-1 in ascending pop order.
- R2: An accepted rename of a non-zero integer or float register behaves as follows. `ren_new` is the head of that class's pool, and pools pop in FIFO order. `ren_prev` is the mapping held before the rename. From the next clock edge, the lookup port returns `ren_new` for that register.
- R3: A rename of the integer zero register (index INT_ZERO, default 31) is handled without allocation. `ren_ready` is 1 and `ren_new` equals INT_ZERO. `ren_prev` is the current table entry. No pool entry is consumed and the table is unchanged.
- R4: When FP_ZERO_EN is 1, the float zero register (index FP_ZERO, default 63) is treated the same way as in R3. `ren_new` equals FP_ZERO, and neither the table nor the float pool changes.
- R5: For an architectural index a ≥ NLI+NLF, both the lookup result and a rename's `ren_new` and `ren_prev` equal a − (NLI+NLF) + (NPI+NPF). Such a rename is always ready and changes nothing.
- R6: Every integer allocation lies in [0, NPI). Every float allocation lies in [NPI, NPI+NPF).
- R7: A set-entry writes `set_phys` into the mapping of an integer or float register on the next edge. A set-entry to a miscellaneous index has no effect. If a set-entry and a rename hit the same register in one cycle, the set-entry value is the one kept.
- R8: `free_slots` equals the minimum of the integer and float pool occupancies.
- R9: A non-zero integer or float rename is refused (`ren_ready` = 0) while its pool is empty. A refused rename leaves the table and the pools unchanged.
- R10: A release of p < NPI pushes p into the integer pool tail. A release of NPI ≤ p < NPI+NPF pushes p into the float pool tail. A release of any higher index is accepted and ignored. `rel_ready` is 0 only when the target pool is full.
- R11: `look_phys` is a combinational function of `look_arch` and the current tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| look_arch | input | ARCH_W | Architectural index to look up |
| look_phys | output | PHYS_W | Current physical mapping of `look_arch` |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_arch | input | ARCH_W | Destination architectural index to rename |
| ren_new | output | PHYS_W | Newly assigned physical register |
| ren_prev | output | PHYS_W | Physical register mapped before the rename |
| set_valid | input | 1 | Overwrite a mapping |
| set_arch | input | ARCH_W | Architectural index to overwrite |
| set_phys | input | PHYS_W | Physical index to store |
| rel_valid | input | 1 | Release a physical register |
| rel_ready | output | 1 | Target pool has room |
| rel_phys | input | PHYS_W | Physical register being released |
| free_slots | output | FREE_W | Minimum of the two pool occupancies |

## Verification
The stall path is the hardest state to reach from the ports, because the integer pool starts with NPI−NLI entries and only drains through accepted renames. The stimulus renames one integer register over and over until a model of the pool reports empty. It then shows that a further request is refused, and reads the refused register through the lookup port to confirm that its mapping did not move. It then releases registers one at a time to check FIFO refill order and `free_slots` recovery.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FP   = 2'd1,
    RC_MISC = 2'd2
  } reg_class_e;
endpackage

// File: rtl/rmap_table.sv
module rmap_table #(
  parameter int N    = 32,
  parameter int PW   = 8,
  parameter int BASE = 0,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd0_idx,
  output logic [PW-1:0] rd0_phys,
  input  logic [IW-1:0] rd1_idx,
  output logic [PW-1:0] rd1_phys,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  logic [PW-1:0] wa_phys,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [PW-1:0] wb_phys
);
  logic [PW-1:0] ent [N];

  assign rd0_phys = ent[rd0_idx];
  assign rd1_phys = ent[rd1_idx];

  // Port b (restore) is applied after port a (rename) so it wins on a clash.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent[i] <= PW'(BASE + i);
    end else begin
      if (wa_en) ent[wa_idx] <= wa_phys;
      if (wb_en) ent[wb_idx] <= wb_phys;
    end
  end
endmodule

// File: rtl/rfree_pool.sv
module rfree_pool #(
  parameter int DEPTH    = 64,
  parameter int PW       = 8,
  parameter int FIRST    = 32,
  parameter int INIT_CNT = 32,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head_phys,
  output logic          nonempty,
  input  logic          push,
  input  logic [PW-1:0] push_phys,
  output logic          has_room,
  output logic [CW-1:0] cnt
);
  localparam logic [AW-1:0] TAIL0 = AW'(INIT_CNT % DEPTH);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] hd, tl;

  assign head_phys = mem[hd];
  assign nonempty  = (cnt != '0);
  assign has_room  = (cnt != CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT_CNT) ? PW'(FIRST + i) : '0;
      hd  <= '0;
      tl  <= TAIL0;
      cnt <= CW'(INIT_CNT);
    end else begin
      if (pop)  hd <= (hd == LAST) ? '0 : hd + 1'b1;
      if (push) begin
        mem[tl] <= push_phys;
        tl      <= (tl == LAST) ? '0 : tl + 1'b1;
      end
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int NLI        = 32,
  parameter int NLF        = 32,
  parameter int NPI        = 64,
  parameter int NPF        = 64,
  parameter int ARCH_W     = 7,
  parameter int INT_ZERO   = 31,
  parameter int FP_ZERO    = 63,
  parameter bit FP_ZERO_EN = 1'b1,
  localparam int PHYS_W    = $clog2(NPI + NPF + (1 << ARCH_W) - NLI - NLF),
  localparam int FREE_W    = $clog2(((NPI > NPF) ? NPI : NPF) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] look_arch,
  output logic [PHYS_W-1:0] look_phys,
  input  logic              ren_valid,
  output logic              ren_ready,
  input  logic [ARCH_W-1:0] ren_arch,
  output logic [PHYS_W-1:0] ren_new,
  output logic [PHYS_W-1:0] ren_prev,
  input  logic              set_valid,
  input  logic [ARCH_W-1:0] set_arch,
  input  logic [PHYS_W-1:0] set_phys,
  input  logic              rel_valid,
  output logic              rel_ready,
  input  logic [PHYS_W-1:0] rel_phys,
  output logic [FREE_W-1:0] free_slots
);
  localparam int IIW = (NLI > 1) ? $clog2(NLI) : 1;
  localparam int FIW = (NLF > 1) ? $clog2(NLF) : 1;
  localparam int ICW = $clog2(NPI + 1);
  localparam int FCW = $clog2(NPF + 1);
  localparam logic [ARCH_W-1:0] FP_LO   = ARCH_W'(NLI);
  localparam logic [ARCH_W-1:0] MISC_LO = ARCH_W'(NLI + NLF);
  localparam logic [ARCH_W-1:0] IZ_A    = ARCH_W'(INT_ZERO);
  localparam logic [ARCH_W-1:0] FZ_A    = ARCH_W'(FP_ZERO);
  localparam logic [PHYS_W-1:0] PF_LO   = PHYS_W'(NPI);
  localparam logic [PHYS_W-1:0] PF_HI   = PHYS_W'(NPI + NPF);

  function automatic reg_class_e classify(input logic [ARCH_W-1:0] a);
    if (a < FP_LO)        return RC_INT;
    else if (a < MISC_LO) return RC_FP;
    else                  return RC_MISC;
  endfunction

  function automatic logic [PHYS_W-1:0] misc_map(input logic [ARCH_W-1:0] a);
    return PHYS_W'(32'(a) - 32'(NLI + NLF) + 32'(NPI + NPF));
  endfunction

  function automatic logic [FIW-1:0] fp_index(input logic [ARCH_W-1:0] a);
    logic [ARCH_W-1:0] d;
    d = a - FP_LO;
    return d[FIW-1:0];
  endfunction

  reg_class_e lk_c, rn_c, st_c;
  assign lk_c = classify(look_arch);
  assign rn_c = classify(ren_arch);
  assign st_c = classify(set_arch);

  logic [PHYS_W-1:0] i_lk, i_rn, f_lk, f_rn, i_head, f_head;
  logic              i_ne, f_ne, i_room, f_room;
  logic [ICW-1:0]    i_cnt;
  logic [FCW-1:0]    f_cnt;

  logic rn_izero, rn_fzero, rn_zero, fire, i_pop, f_pop;
  assign rn_izero = (rn_c == RC_INT) && (ren_arch == IZ_A);
  assign rn_fzero = FP_ZERO_EN && (rn_c == RC_FP) && (ren_arch == FZ_A);
  assign rn_zero  = rn_izero || rn_fzero;

  always_comb begin
    unique case (rn_c)
      RC_INT:  ren_ready = rn_zero || i_ne;
      RC_FP:   ren_ready = rn_zero || f_ne;
      default: ren_ready = 1'b1;
    endcase
  end

  assign fire  = ren_valid && ren_ready;
  assign i_pop = fire && (rn_c == RC_INT) && !rn_zero;
  assign f_pop = fire && (rn_c == RC_FP)  && !rn_zero;

  always_comb begin
    unique case (rn_c)
      RC_INT: begin
        ren_prev = i_rn;
        ren_new  = rn_zero ? PHYS_W'(INT_ZERO) : i_head;
      end
      RC_FP: begin
        ren_prev = f_rn;
        ren_new  = rn_zero ? PHYS_W'(FP_ZERO) : f_head;
      end
      default: begin
        ren_prev = misc_map(ren_arch);
        ren_new  = misc_map(ren_arch);
      end
    endcase
  end

  always_comb begin
    unique case (lk_c)
      RC_INT:  look_phys = i_lk;
      RC_FP:   look_phys = f_lk;
      default: look_phys = misc_map(look_arch);
    endcase
  end

  // Release routing by physical range; higher indices are swallowed.
  logic rel_i, rel_f;
  assign rel_i     = (rel_phys < PF_LO);
  assign rel_f     = !rel_i && (rel_phys < PF_HI);
  assign rel_ready = rel_i ? i_room : (rel_f ? f_room : 1'b1);

  rmap_table #(.N(NLI), .PW(PHYS_W), .BASE(0)) u_itab (
    .clk, .rst_n,
    .rd0_idx(look_arch[IIW-1:0]), .rd0_phys(i_lk),
    .rd1_idx(ren_arch[IIW-1:0]),  .rd1_phys(i_rn),
    .wa_en(i_pop), .wa_idx(ren_arch[IIW-1:0]), .wa_phys(i_head),
    .wb_en(set_valid && (st_c == RC_INT)), .wb_idx(set_arch[IIW-1:0]),
    .wb_phys(set_phys)
  );

  rmap_table #(.N(NLF), .PW(PHYS_W), .BASE(NPI)) u_ftab (
    .clk, .rst_n,
    .rd0_idx(fp_index(look_arch)), .rd0_phys(f_lk),
    .rd1_idx(fp_index(ren_arch)),  .rd1_phys(f_rn),
    .wa_en(f_pop), .wa_idx(fp_index(ren_arch)), .wa_phys(f_head),
    .wb_en(set_valid && (st_c == RC_FP)), .wb_idx(fp_index(set_arch)),
    .wb_phys(set_phys)
  );

  rfree_pool #(.DEPTH(NPI), .PW(PHYS_W), .FIRST(NLI), .INIT_CNT(NPI - NLI)) u_ipool (
    .clk, .rst_n, .pop(i_pop), .head_phys(i_head), .nonempty(i_ne),
    .push(rel_valid && rel_i && i_room), .push_phys(rel_phys),
    .has_room(i_room), .cnt(i_cnt)
  );

  rfree_pool #(.DEPTH(NPF), .PW(PHYS_W), .FIRST(NPI + NLF), .INIT_CNT(NPF - NLF)) u_fpool (
    .clk, .rst_n, .pop(f_pop), .head_phys(f_head), .nonempty(f_ne),
    .push(rel_valid && rel_f && f_room), .push_phys(rel_phys),
    .has_room(f_room), .cnt(f_cnt)
  );

  logic [FREE_W-1:0] i_cnt_w, f_cnt_w;
  assign i_cnt_w    = FREE_W'(i_cnt);
  assign f_cnt_w    = FREE_W'(f_cnt);
  assign free_slots = (i_cnt_w < f_cnt_w) ? i_cnt_w : f_cnt_w;
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NLI        = 32,
  parameter int NLF        = 32,
  parameter int NPI        = 64,
  parameter int NPF        = 64,
  parameter int ARCH_W     = 7,
  parameter int INT_ZERO   = 31,
  parameter int FP_ZERO    = 63,
  parameter bit FP_ZERO_EN = 1'b1,
  parameter int PHYS_W     = 8,
  parameter int FREE_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ARCH_W-1:0] look_arch,
  input logic [PHYS_W-1:0] look_phys,
  input logic              ren_valid,
  input logic              ren_ready,
  input logic [ARCH_W-1:0] ren_arch,
  input logic [PHYS_W-1:0] ren_new,
  input logic [PHYS_W-1:0] ren_prev,
  input logic              set_valid,
  input logic [ARCH_W-1:0] set_arch,
  input logic [PHYS_W-1:0] set_phys,
  input logic              rel_valid,
  input logic              rel_ready,
  input logic [PHYS_W-1:0] rel_phys,
  input logic [FREE_W-1:0] free_slots
);
  localparam logic [ARCH_W-1:0] FP_LO   = ARCH_W'(NLI);
  localparam logic [ARCH_W-1:0] MISC_LO = ARCH_W'(NLI + NLF);
  localparam logic [ARCH_W-1:0] IZ_A    = ARCH_W'(INT_ZERO);
  localparam logic [ARCH_W-1:0] FZ_A    = ARCH_W'(FP_ZERO);
  localparam logic [PHYS_W-1:0] PF_LO   = PHYS_W'(NPI);
  localparam logic [PHYS_W-1:0] PF_HI   = PHYS_W'(NPI + NPF);

  logic a_int, a_fp, a_zero, alloc;
  assign a_int  = ren_arch < FP_LO;
  assign a_fp   = !a_int && (ren_arch < MISC_LO);
  assign a_zero = (a_int && ren_arch == IZ_A) || (FP_ZERO_EN && a_fp && ren_arch == FZ_A);
  assign alloc  = ren_valid && ren_ready && (a_int || a_fp) && !a_zero;

  p_zero_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_arch == IZ_A) |-> (ren_ready && ren_new == PHYS_W'(INT_ZERO)));

  p_misc_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_arch >= MISC_LO) |-> (ren_ready && ren_new == ren_prev));

  p_int_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && a_int) |-> (ren_new < PF_LO));

  p_fp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && a_fp) |-> (ren_new >= PF_LO && ren_new < PF_HI));

  p_lookup_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !(set_valid && set_arch == ren_arch)) |=>
      (look_arch != $past(ren_arch) || look_phys == $past(ren_new)));

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready && !set_valid) |=>
      (look_arch != $past(ren_arch) || look_phys == $past(ren_prev)));

  p_free_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !rel_valid) |=> (free_slots <= $past(free_slots)));
endmodule

bind rename_map rename_map_chk #(
  .NLI(NLI), .NLF(NLF), .NPI(NPI), .NPF(NPF), .ARCH_W(ARCH_W),
  .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .FP_ZERO_EN(FP_ZERO_EN),
  .PHYS_W(PHYS_W), .FREE_W(FREE_W)
) u_chk (.*);

// File: tb/tb_rename_map.sv
module tb_rename_map;
  localparam int NLI = 32, NLF = 32, NPI = 64, NPF = 64, ARCH_W = 7;
  localparam int PHYS_W = 8, FREE_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ARCH_W-1:0] look_arch = '0, ren_arch = '0, set_arch = '0;
  logic [PHYS_W-1:0] look_phys, ren_new, ren_prev, set_phys = '0, rel_phys = '0;
  logic ren_valid = 1'b0, set_valid = 1'b0, rel_valid = 1'b0;
  logic ren_ready, rel_ready;
  logic [FREE_W-1:0] free_slots;

  always #2 clk = ~clk;

  rename_map dut (.*);

  typedef struct {
    bit cr; int er; bit cn; int en; bit cp; int ep;
    int el; int ef; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  int imap[NLI];
  int fmap[NLF];
  int ipool[$];
  int fpool[$];

  task automatic cmp(string tag, string what, int act, int ex);
    checks++;
    if (act != ex) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, ex);
    end
  endtask

  // Monitor: compares the combinational outputs one time unit after each drive.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.cr) cmp(e.tag, "ren_ready", int'(ren_ready), e.er);
        if (e.cn) cmp(e.tag, "ren_new", int'(ren_new), e.en);
        if (e.cp) cmp(e.tag, "ren_prev", int'(ren_prev), e.ep);
        cmp(e.tag, "look_phys", int'(look_phys), e.el);
        cmp(e.tag, "free_slots", int'(free_slots), e.ef);
      end
    end
  end

  function automatic int mlook(int a);
    if (a < NLI) return imap[a];
    if (a < NLI + NLF) return fmap[a - NLI];
    return a - (NLI + NLF) + NPI + NPF;
  endfunction

  function automatic int mfree();
    return (ipool.size() < fpool.size()) ? ipool.size() : fpool.size();
  endfunction

  // Driver: applies one cycle of stimulus, queues the expectation, then updates the model.
  task automatic op(bit rv, int ra, bit sv, int sa, int sp, bit lv, int lp, int la, string tag);
    exp_t e;
    bit rdy, isz, alloc;
    int nw, pv;
    @(negedge clk);
    ren_valid = rv; ren_arch = ARCH_W'(ra);
    set_valid = sv; set_arch = ARCH_W'(sa); set_phys = PHYS_W'(sp);
    rel_valid = lv; rel_phys = PHYS_W'(lp);
    look_arch = ARCH_W'(la);
    isz = (ra == 31) || (ra == 63);
    alloc = 1'b0; nw = 0;
    pv = mlook(ra);
    if (ra >= NLI + NLF) begin rdy = 1; nw = pv; end
    else if (isz) begin rdy = 1; nw = ra; end
    else if (ra < NLI) begin rdy = (ipool.size() > 0); if (rdy) nw = ipool[0]; alloc = rdy; end
    else begin rdy = (fpool.size() > 0); if (rdy) nw = fpool[0]; alloc = rdy; end
    e.cr = rv; e.er = rdy; e.cn = rv && rdy; e.en = nw; e.cp = rv; e.ep = pv;
    e.el = mlook(la); e.ef = mfree(); e.tag = tag;
    q.push_back(e);
    if (rv && alloc) begin
      if (ra < NLI) begin imap[ra] = nw; void'(ipool.pop_front()); end
      else begin fmap[ra - NLI] = nw; void'(fpool.pop_front()); end
    end
    if (sv && sa < NLI) imap[sa] = sp;
    else if (sv && sa < NLI + NLF) fmap[sa - NLI] = sp;
    if (lv && lp < NPI) ipool.push_back(lp);
    else if (lv && lp < NPI + NPF) fpool.push_back(lp);
  endtask

  task automatic look(int a, string tag);
    op(0, 0, 0, 0, 0, 0, 0, a, tag);
  endtask

  initial begin
    for (int i = 0; i < NLI; i++) imap[i] = i;
    for (int i = 0; i < NLF; i++) fmap[i] = NPI + i;
    for (int p = NLI; p < NPI; p++) ipool.push_back(p);
    for (int p = NPI + NLF; p < NPI + NPF; p++) fpool.push_back(p);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset mapping, R5 misc lookup, R8 initial free count, R11 lookup
    look(0, "R1 int base");
    look(31, "R1 int zero map");
    look(32, "R1 fp base");
    look(63, "R1 fp top");
    look(70, "R5 misc lookup");
    look(127, "R5 misc top");
    // R2 rename int and fp, R6 ranges
    op(1, 5, 0, 0, 0, 0, 0, 5, "R2 int rename");
    look(5, "R2 int table updated");
    op(1, 40, 0, 0, 0, 0, 0, 40, "R2 R6 fp rename");
    look(40, "R2 fp table updated");
    op(1, 5, 0, 0, 0, 0, 0, 5, "R2 prev is last alloc");
    // R3 int zero, R4 fp zero
    op(1, 31, 0, 0, 0, 0, 0, 31, "R3 int zero");
    look(31, "R3 table unchanged");
    op(1, 63, 0, 0, 0, 0, 0, 63, "R4 fp zero");
    look(63, "R4 table unchanged");
    // R5 misc rename
    op(1, 70, 0, 0, 0, 0, 0, 70, "R5 misc rename");
    // R7 set-entry, misc ignored, set wins over rename
    op(0, 0, 1, 5, 7, 0, 0, 5, "R7 set int");
    look(5, "R7 set int visible");
    op(0, 0, 1, 100, 3, 0, 0, 100, "R7 set misc");
    look(100, "R7 set misc ignored");
    op(1, 9, 1, 9, 44, 0, 0, 9, "R7 set vs rename");
    look(9, "R7 set wins");
    op(0, 0, 1, 33, 90, 0, 0, 33, "R7 set fp");
    look(33, "R7 set fp visible");
    // R9 drain the integer pool, then stall
    while (ipool.size() > 0) op(1, 1, 0, 0, 0, 0, 0, 1, "R2 R8 drain");
    look(1, "R8 free zero");
    op(1, 2, 0, 0, 0, 0, 0, 2, "R9 stall");
    look(2, "R9 stall no change");
    op(1, 31, 0, 0, 0, 0, 0, 31, "R3 zero while empty");
    // R10 release routing and FIFO refill order
    op(0, 0, 0, 0, 0, 1, 12, 0, "R10 rel int a");
    op(0, 0, 0, 0, 0, 1, 20, 0, "R10 rel int b");
    op(0, 0, 0, 0, 0, 1, 150, 0, "R10 rel misc");
    look(0, "R8 R10 free after rel");
    op(0, 0, 0, 0, 0, 1, 100, 0, "R10 rel fp");
    op(1, 2, 0, 0, 0, 0, 0, 2, "R10 FIFO first");
    op(1, 3, 0, 0, 0, 0, 0, 3, "R10 FIFO second");
    op(1, 4, 0, 0, 0, 0, 0, 4, "R9 stall again");
    op(1, 7, 0, 0, 0, 1, 22, 7, "R9 R10 rel same cycle");
    op(1, 7, 0, 0, 0, 0, 0, 7, "R10 refilled");
    look(7, "R2 final");
    op(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule